// File: doc/BRIEF.md
# Row-Batched DRAM Ring-Buffer Scheduler

This block keeps a circular buffer in external DRAM between a free-running input stream and an on-demand playback stream. Incoming words go into an on-chip staging FIFO. The block never pushes back on the producer. Whenever a whole row's worth of words is waiting, the scheduler writes it to DRAM as one uninterrupted burst of column addresses. After an external trigger, the block also fetches stored rows back, again as whole-row bursts, into an on-chip playback FIFO. The consumer drains that FIFO through a valid/ready port.

The DRAM word address has three fields. The bank index sits in the most significant bits, the row index in the middle bits and the column index in the least significant bits. A burst holds exactly one column range, so it always starts at column zero and never leaves the row it opened. Because each burst keeps one direction, DRAM bus turnarounds happen only between bursts. The DRAM controller itself sits behind a command handshake, and it returns read data in order with arbitrary latency.

Top module: `rowbatch_ring_sched`

## Requirements
- R1: While reset is held and after it is released, with no stimulus applied, `mem_cmd_valid`, `out_valid`, `overflow` and `underflow` are all low.
- R2: A burst is 2^COL_W commands of one direction. All of them carry the same upper address bits {bank, row}. The column field, in the low COL_W bits of `mem_cmd_addr`, runs 0, 1, ... up to its maximum in order of acceptance.
- R3: A write burst starts only when the input FIFO held at least 2^COL_W words in the cycle of the decision. Write data leaves in arrival order. Each write burst uses the next row slot: {bank,row} is incremented as one counter, and it wraps from all ones to zero.
- R4: No read command is issued before the first trigger. A trigger sets the read slot to the first write slot not yet completed at that edge. Playback then delivers the written words from that slot onward, in order, as long as no overflow occurs.
- R5: A read burst starts only while at least one completed, unread slot exists. It also needs room for a whole burst in the output FIFO, counting the reads still in flight.
- R6: When the port is idle and a write burst is eligible, the next burst is a write, starting on the following cycle. If no write is eligible and a read is, the next burst is a read. Otherwise `mem_cmd_valid` stays low.
- R7: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command holds its address, direction and data into the next cycle.
- R8: Returned read words reach `out_data` in return order. `out_valid` is high exactly when the output FIFO is non-empty.
- R9: `overflow` is sticky. It sets when a write burst completes during playback while every slot is unread; in that case the oldest slot is discarded and the read slot skips forward by one. It also sets when an input word arrives while the input FIFO is full; that word is discarded.
- R10: `underflow` is sticky. It sets when `out_ready` is high during playback while the output FIFO is empty.
- R11: A trigger that arrives while playback is already running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word present this cycle (no backpressure) |
| in_data | input | DATA_W | Input word |
| trigger | input | 1 | Starts playback (first assertion only) |
| out_ready | input | 1 | Consumer takes a word |
| out_valid | output | 1 | Playback word available |
| out_data | output | DATA_W | Playback word |
| mem_cmd_valid | output | 1 | DRAM command request |
| mem_cmd_ready | input | 1 | DRAM controller accepts the command |
| mem_cmd_we | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | BANK_W+ROW_W+COL_W | Word address {bank, row, column} |
| mem_cmd_wdata | output | DATA_W | Write data |
| mem_rd_valid | input | 1 | Read data return, in request order |
| mem_rd_data | input | DATA_W | Returned read word |
| overflow | output | 1 | Sticky: slot lapped or input word lost |
| underflow | output | 1 | Sticky: playback requested from an empty FIFO |

## Verification
The hardest state to reach is the lap. In that state every slot of the ring holds unread data when another write burst completes. The consumer must therefore stall long enough for the output FIFO to refuse further read bursts, while the producer keeps filling rows. The stimulus holds `out_ready` low for several hundred cycles with input still flowing. It then drains fully, and the reference model follows the skipped read slot. A wrap of the write slot before the trigger comes from a long input-only phase, and a late second trigger probes that a repeat trigger is ignored.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } batch_st_e;
endpackage

// File: rtl/rbs_fifo.sv
module rbs_fifo #(
  parameter int W     = 512,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_push, do_pop;

  // Push is refused when full, pop when empty (depth is a power of two).
  always_comb begin
    do_push = push && (cnt != CW'(DEPTH));
    do_pop  = pop && (cnt != '0);
    wp_n    = wp + AW'(do_push);
    rp_n    = rp + AW'(do_pop);
    cnt_n   = cnt + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];
  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/rbs_sched.sv
module rbs_sched
  import rbs_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 15,
  parameter int COL_W     = 7,
  parameter int IN_CW     = 9,
  parameter int OUT_CW    = 9,
  parameter int OUT_DEPTH = 256
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [IN_CW-1:0]                in_count,
  input  logic [OUT_CW-1:0]               out_count,
  input  logic                            trig,
  input  logic                            cmd_ready,
  input  logic                            rd_valid,
  output logic                            cmd_valid,
  output logic                            cmd_we,
  output logic [BANK_W+ROW_W+COL_W-1:0]   cmd_addr,
  output logic                            in_pop,
  output logic                            playing,
  output logic                            overflow
);
  localparam int SLOT_W = BANK_W + ROW_W;
  localparam int BATCH  = 1 << COL_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int FILL_W = SLOT_W + 1;
  localparam int PEND_W = $clog2(OUT_DEPTH + 1);

  batch_st_e          st, st_n;
  logic [COL_W-1:0]   col, col_n;
  logic [SLOT_W-1:0]  wr_slot, wr_slot_n, rd_slot, rd_slot_n;
  logic [FILL_W-1:0]  fill, fill_n;
  logic [PEND_W-1:0]  pend, pend_n;
  logic               play, play_n, ovf, ovf_n;
  logic               wr_elig, rd_elig, room, accept, col_last, wr_done, rd_done;

  always_comb begin
    wr_elig  = int'(in_count) >= BATCH;
    room     = (int'(out_count) + int'(pend) + BATCH) <= OUT_DEPTH;
    rd_elig  = play && (fill != '0) && room;
    accept   = (st != ST_IDLE) && cmd_ready;
    col_last = (col == '1);
    wr_done  = accept && (st == ST_WRITE) && col_last;
    rd_done  = accept && (st == ST_READ) && col_last;
  end

  // Next-state logic
  always_comb begin
    st_n      = st;
    col_n     = col;
    wr_slot_n = wr_slot;
    rd_slot_n = rd_slot;
    fill_n    = fill;
    play_n    = play;
    ovf_n     = ovf;
    pend_n    = pend + PEND_W'(accept && (st == ST_READ)) - PEND_W'(rd_valid);

    case (st)
      ST_IDLE: begin
        col_n = '0;
        if (wr_elig)      st_n = ST_WRITE;
        else if (rd_elig) st_n = ST_READ;
      end
      ST_WRITE: begin
        if (accept) col_n = col + COL_W'(1);
        if (wr_done) begin
          st_n      = ST_IDLE;
          wr_slot_n = wr_slot + SLOT_W'(1);
        end
      end
      ST_READ: begin
        if (accept) col_n = col + COL_W'(1);
        if (rd_done) begin
          st_n      = ST_IDLE;
          rd_slot_n = rd_slot + SLOT_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase

    if (trig && !play) begin
      play_n    = 1'b1;
      rd_slot_n = wr_slot;
      fill_n    = wr_done ? FILL_W'(1) : '0;
    end else if (play) begin
      if (wr_done) begin
        if (fill == FILL_W'(NSLOT)) begin
          ovf_n     = 1'b1;
          rd_slot_n = rd_slot + SLOT_W'(1);
        end else begin
          fill_n = fill + FILL_W'(1);
        end
      end
      if (rd_done) fill_n = fill - FILL_W'(1);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      col     <= '0;
      wr_slot <= '0;
      rd_slot <= '0;
      fill    <= '0;
      pend    <= '0;
      play    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      st      <= st_n;
      col     <= col_n;
      wr_slot <= wr_slot_n;
      rd_slot <= rd_slot_n;
      fill    <= fill_n;
      pend    <= pend_n;
      play    <= play_n;
      ovf     <= ovf_n;
    end
  end

  assign cmd_valid = (st != ST_IDLE);
  assign cmd_we    = (st == ST_WRITE);
  assign cmd_addr  = {(st == ST_WRITE) ? wr_slot : rd_slot, col};
  assign in_pop    = accept && (st == ST_WRITE);
  assign playing   = play;
  assign overflow  = ovf;

  p_batch_col0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> (cmd_addr[COL_W-1:0] == '0));

  p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_we)));

  p_no_early_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_we) |-> playing);

  p_write_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && !cmd_we) |-> ($past(int'(in_count)) < BATCH));

  p_out_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(out_count) + int'(pend)) <= OUT_DEPTH);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(NSLOT));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/rowbatch_ring_sched.sv
module rowbatch_ring_sched #(
  parameter int DATA_W    = 512,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 15,
  parameter int COL_W     = 7,
  parameter int IN_DEPTH  = 256,
  parameter int OUT_DEPTH = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          trigger,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [DATA_W-1:0]             out_data,
  output logic                          mem_cmd_valid,
  input  logic                          mem_cmd_ready,
  output logic                          mem_cmd_we,
  output logic [BANK_W+ROW_W+COL_W-1:0] mem_cmd_addr,
  output logic [DATA_W-1:0]             mem_cmd_wdata,
  input  logic                          mem_rd_valid,
  input  logic [DATA_W-1:0]             mem_rd_data,
  output logic                          overflow,
  output logic                          underflow
);
  localparam int IN_CW  = $clog2(IN_DEPTH) + 1;
  localparam int OUT_CW = $clog2(OUT_DEPTH) + 1;

  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [IN_CW-1:0]  in_count;
  logic [OUT_CW-1:0] out_count;
  logic              in_empty, in_full, out_empty, out_full;
  logic              in_pop, playing, sched_ovf;
  logic              drop_seen, drop_seen_n, unf, unf_n;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  rbs_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk(clk), .rst_n(rst_q),
    .push(in_valid), .wdata(in_data),
    .pop(in_pop), .rdata(mem_cmd_wdata),
    .count(in_count), .empty(in_empty), .full(in_full)
  );

  rbs_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk(clk), .rst_n(rst_q),
    .push(mem_rd_valid), .wdata(mem_rd_data),
    .pop(out_ready), .rdata(out_data),
    .count(out_count), .empty(out_empty), .full(out_full)
  );

  rbs_sched #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .IN_CW(IN_CW), .OUT_CW(OUT_CW), .OUT_DEPTH(OUT_DEPTH)
  ) u_sched (
    .clk(clk), .rst_n(rst_q),
    .in_count(in_count), .out_count(out_count),
    .trig(trigger), .cmd_ready(mem_cmd_ready), .rd_valid(mem_rd_valid),
    .cmd_valid(mem_cmd_valid), .cmd_we(mem_cmd_we), .cmd_addr(mem_cmd_addr),
    .in_pop(in_pop), .playing(playing), .overflow(sched_ovf)
  );

  always_comb begin
    drop_seen_n = drop_seen | (in_valid && in_full);
    unf_n       = unf | (playing && out_ready && out_empty);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      drop_seen <= 1'b0;
      unf       <= 1'b0;
    end else begin
      drop_seen <= drop_seen_n;
      unf       <= unf_n;
    end
  end

  assign out_valid = !out_empty;
  assign overflow  = sched_ovf | drop_seen;
  assign underflow = unf;

  p_pop_has_data_r3: assert property (@(posedge clk) disable iff (!rst_q)
    in_pop |-> !in_empty);

  p_return_room_r5: assert property (@(posedge clk) disable iff (!rst_q)
    mem_rd_valid |-> !out_full);

  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_q)
    unf |=> unf);
endmodule

// File: tb/sim_rowbatch_ring_sched.sv
module sim_rowbatch_ring_sched;
  localparam int DW = 16, BW = 1, RW = 2, CWD = 2, IND = 16, OUTD = 8;
  localparam int BATCH = 4, NS = 8, AW = 5;

  logic          clk, rst_n, in_valid, trigger, out_ready, out_valid;
  logic [DW-1:0] in_data, out_data, cmd_wdata, rd_data;
  logic          cmd_valid, cmd_ready, cmd_we, rd_valid, overflow, underflow;
  logic [AW-1:0] cmd_addr;

  rowbatch_ring_sched #(
    .DATA_W(DW), .BANK_W(BW), .ROW_W(RW), .COL_W(CWD),
    .IN_DEPTH(IND), .OUT_DEPTH(OUTD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .trigger(trigger), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .mem_cmd_valid(cmd_valid), .mem_cmd_ready(cmd_ready),
    .mem_cmd_we(cmd_we), .mem_cmd_addr(cmd_addr), .mem_cmd_wdata(cmd_wdata),
    .mem_rd_valid(rd_valid), .mem_rd_data(rd_data),
    .overflow(overflow), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  task automatic check_eq(string req, string what, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Stimulus knobs (percent)
  int in_rate = 0, rdy_rate = 0, out_rate = 0;
  bit trig_req = 0, run_model = 0;

  // Reference model
  logic [DW-1:0] in_q[$], out_q[$], wlist[$], ret_data[$];
  int            ret_due[$];
  logic [DW-1:0] mem [AW**0 * 32];
  int  m_st = 0, wr_slot = 0, rd_slot = 0, wr_col = 0, rd_col = 0;
  int  fill = 0, pend = 0, out_occ = 0, cyc = 0, last_due = 0;
  int  start_idx = 0, out_n = 0, done_wr = 0;
  bit  play_m = 0, ovf_m = 0, unf_m = 0, e2e_ok = 1;
  bit  hold_prev = 0, prev_we = 0;
  int  prev_addr = 0;
  bit  acc, wd, rdn, wr_el, rd_el;
  int  a, due, pre_in, pre_fill, pre_out, pre_pend;
  logic [DW-1:0] d;

  always @(negedge clk) begin
    if (run_model) begin
      // 1. compare outputs with the model state after the last edge
      check_eq("R8", "out_valid", out_valid, out_occ > 0);
      check_eq("R9", "overflow", overflow, ovf_m);
      check_eq("R10", "underflow", underflow, unf_m);
      check_eq("R6", "mem_cmd_valid", cmd_valid, m_st != 0);
      if (!play_m) check_eq("R4", "read before trigger", cmd_valid && !cmd_we, 0);
      if (m_st != 0) begin
        check_eq("R6", "mem_cmd_we", cmd_we, m_st == 1);
        a = (m_st == 1) ? wr_slot * BATCH + wr_col : rd_slot * BATCH + rd_col;
        check_eq("R2", "mem_cmd_addr", cmd_addr, a);
      end
      if (hold_prev) begin
        check_eq("R7", "held addr", cmd_addr, prev_addr);
        check_eq("R7", "held dir", cmd_we, prev_we);
      end

      // 2. drive inputs for the next edge
      in_valid  = ($urandom_range(99, 0) < in_rate);
      in_data   = DW'($urandom);
      cmd_ready = ($urandom_range(99, 0) < rdy_rate);
      out_ready = ($urandom_range(99, 0) < out_rate);
      trigger   = trig_req;
      trig_req  = 0;
      if (ret_due.size() > 0 && ret_due[0] <= cyc) begin
        rd_valid = 1'b1;
        rd_data  = ret_data.pop_front();
        void'(ret_due.pop_front());
      end else begin
        rd_valid = 1'b0;
        rd_data  = '0;
      end

      // 3. advance the model across the coming edge
      pre_in = in_q.size(); pre_fill = fill; pre_out = out_occ; pre_pend = pend;
      hold_prev = cmd_valid && !cmd_ready;
      prev_addr = cmd_addr; prev_we = cmd_we;
      acc = (m_st != 0) && cmd_ready;
      wd = acc && m_st == 1 && wr_col == BATCH - 1;
      rdn = acc && m_st == 2 && rd_col == BATCH - 1;
      wr_el = pre_in >= BATCH;
      rd_el = play_m && pre_fill >= 1 && (pre_out + pre_pend + BATCH <= OUTD);

      if (acc && m_st == 1) begin
        check_eq("R3", "write data order", cmd_wdata, in_q[0]);
        d = in_q.pop_front();
        mem[wr_slot * BATCH + wr_col] = d;
        wlist.push_back(d);
        wr_col++;
      end
      if (acc && m_st == 2) begin
        ret_data.push_back(mem[rd_slot * BATCH + rd_col]);
        due = cyc + 1 + $urandom_range(3, 0);
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        ret_due.push_back(due);
        rd_col++;
        pend++;
      end
      if (m_st == 0) m_st = wr_el ? 1 : (rd_el ? 2 : 0);
      if (wd) begin m_st = 0; wr_col = 0; end
      if (rdn) begin m_st = 0; rd_col = 0; end

      if (in_valid) begin
        if (pre_in == IND) ovf_m = 1;
        else in_q.push_back(in_data);
      end

      if (out_ready && pre_out == 0 && play_m) unf_m = 1;
      if (out_ready && pre_out > 0) begin
        d = out_q.pop_front();
        check_eq("R8", "out order", out_data, d);
        if (e2e_ok && start_idx + out_n < wlist.size())
          check_eq("R4,R11", "playback word", out_data, wlist[start_idx + out_n]);
        out_n++;
        out_occ--;
      end
      if (rd_valid) begin
        out_q.push_back(rd_data);
        out_occ++;
        pend--;
      end

      if (trigger && !play_m) begin
        play_m = 1;
        rd_slot = wr_slot;
        start_idx = done_wr * BATCH;
        fill = wd ? 1 : 0;
      end else if (play_m) begin
        if (wd) begin
          if (fill == NS) begin
            ovf_m = 1; e2e_ok = 0;
            rd_slot = (rd_slot + 1) % NS;
          end else fill++;
        end
        if (rdn) fill--;
      end
      if (wd) begin wr_slot = (wr_slot + 1) % NS; done_wr++; end
      if (rdn) rd_slot = (rd_slot + 1) % NS;
      cyc++;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    rst_n = 1'b0; in_valid = 0; in_data = '0; trigger = 0; out_ready = 0;
    cmd_ready = 0; rd_valid = 0; rd_data = '0;
    wait_cyc(3);
    @(negedge clk);
    check_eq("R1", "cmd_valid in reset", cmd_valid, 0);
    check_eq("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    @(negedge clk);
    check_eq("R1", "cmd_valid after reset", cmd_valid, 0);
    check_eq("R1", "out_valid after reset", out_valid, 0);
    check_eq("R1", "overflow after reset", overflow, 0);
    check_eq("R1", "underflow after reset", underflow, 0);
    @(posedge clk);
    run_model = 1;

    // input only, long enough for the write slot to wrap (R3)
    in_rate = 30; rdy_rate = 80; out_rate = 0;
    wait_cyc(160);
    check_eq("R4", "no playback before trigger", out_valid, 0);

    // start playback (R4), consumer running
    trig_req = 1;
    in_rate = 25; out_rate = 60;
    wait_cyc(300);
    // repeat trigger while playing (R11)
    trig_req = 1;
    wait_cyc(300);
    @(negedge clk); #1;
    check_eq("R10", "underflow raised", underflow, 1);
    check_eq("R9", "no lap yet", overflow, 0);

    // consumer stalls: ring laps (R9)
    @(posedge clk);
    out_rate = 0;
    wait_cyc(400);
    @(negedge clk); #1;
    check_eq("R9", "lap raises overflow", overflow, 1);

    // drain
    @(posedge clk);
    out_rate = 100; in_rate = 20;
    wait_cyc(300);
    in_rate = 0;
    wait_cyc(100);
    @(negedge clk); #1;
    check_eq("R9", "overflow stays set", overflow, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    wait_cyc(20000);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule